// File: doc/BRIEF.md
# System Control Register File

This block is the register bank a processor core uses for system control. The core issues register-transfer commands to it. Each command carries a 4-bit primary index, a 4-bit secondary index, two 3-bit opcode fields and a privilege flag. For a write it also carries a data word.

The block decides in the same cycle whether the access is legal, and it answers with accept or reject. Legal writes commit at the next clock edge through per-register masks. Those masks keep some bits, force some to zero and force others to one. Legal reads return the register value combinationally.

One primary index can reach different physical registers. Index 0 and index 1 each hold two views, chosen by opcode_2. Index 14 chooses among five breakpoint registers by the secondary index. When a write to the control register flips its byte-order bit, the block raises a one-cycle pulse so that the core can switch endianness.

Indices 7, 8 and 10 stand for cache and translation-buffer maintenance. They accept legal writes, store nothing and read as zero.

Top module: `sysctl_regs`

## Requirements
- R1: An access is rejected (acc_ok low) whenever req_priv is 0, and whenever req_op1 is nonzero.
- R2: After reset, the following values read back: index 0 with opcode_2 = 0 gives 0x69052000; index 0 with opcode_2 nonzero gives 0x0B1AA1AA; index 1 with opcode_2 = 0 gives 0x00000078; every other stored register gives 0. Writes to index 0 are accepted, but the read value does not change. Index 0 and index 1 are legal only with secondary index 0, and any opcode_2 is allowed.
- R3: Control register (index 1, opcode_2 = 0), read-back value = (written & 0x00003B87) | 0x00000078. This keeps bits 13:11, 9:7 and 2:0, reads bits 6:3 as one, and reads bits 31:14 and bit 10 as zero.
- R4: Auxiliary control register (index 1, opcode_2 nonzero), read-back value = written & 0x00000033.
- R5: Masked registers, each legal only with secondary 0 and opcode_2 0 (read-back = written & mask):

  | Register | Index | Mask |
  |---|---|---|
  | Translation base | 2 | 0xFFFFC000 |
  | Domain access | 3 | all bits |
  | Fault status | 5 | 0x000006FF |
  | Fault address | 6 | all bits |
  | Process ID | 13 | 0xFE000000 |
- R6: Index 14 requires opcode_2 = 0 and chooses a breakpoint register by the secondary index. The five legal values are 0, 3, 4, 8 and 9; each names its own fully writable register. Every other secondary value is rejected.
- R7: Index 15 is legal only with secondary index 1 and opcode_2 = 0. It stores bits 13:0 of a write.
- R8: The remaining indices follow these rules, given as (secondary, opcode_2):

  | Index | Legal accesses | Storage |
  |---|---|---|
  | 4, 11, 12 | never legal | none |
  | 7 | opcode_2 0 with secondary 5, 6 or 7; opcode_2 1 with secondary 5, 6 or 10; (10, 4); (2, 5); (5, 6) | reads 0 |
  | 8 | secondary 5 to 7 with opcode_2 0; secondary 5 or 6 with opcode_2 1 | reads 0 |
  | 9 | secondary 1 or 2, opcode_2 0 or 1 | one register holding only bit 0 |
  | 10 | secondary 4 or 8, opcode_2 0 or 1 | reads 0 |
- R9: endian_pulse is high for exactly the one cycle after a clock edge at which an accepted control-register write changed bit 7. Otherwise it is low.
- R10: acc_ok is combinational and valid in the request cycle. A rejected write leaves every register unchanged. rd_data is zero unless the cycle carries an accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| req_crn | input | 4 | Primary register index |
| req_crm | input | 4 | Secondary register index |
| req_op1 | input | 3 | Opcode_1 field |
| req_op2 | input | 3 | Opcode_2 field |
| req_wdata | input | 32 | Write data |
| acc_ok | output | 1 | Access accepted (combinational) |
| rd_data | output | 32 | Read data (combinational, zero unless accepted read) |
| endian_pulse | output | 1 | One-cycle byte-order change indication |

## Verification
The assertions take for granted that the command fields are held stable through each cycle and settle before the clock edge. They also assume that reset is asserted at the start, so the control register begins at its reset value. The stimulus drives every field on the falling edge and samples the combinational answers shortly after. Random commands are biased toward privileged mode, a zero opcode_1 and the small secondary and opcode_2 values that reach legal registers. Directed cases cover the reset values, all-ones writes, the byte-order flip and the rejected corners.

// File: rtl/sysctl_regs.sv
module sysctl_regs #(
  parameter logic [31:0] ID_VALUE    = 32'h6905_2000,
  parameter logic [31:0] CACHE_TYPE  = 32'h0B1A_A1AA,
  parameter logic [31:0] CTRL_RESET  = 32'h0000_0078
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic        req_priv,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op1,
  input  logic [2:0]  req_op2,
  input  logic [31:0] req_wdata,
  output logic        acc_ok,
  output logic [31:0] rd_data,
  output logic        endian_pulse
);
  localparam logic [31:0] CTRL_KEEP = 32'h0000_3B87;
  localparam logic [31:0] CTRL_ONES = 32'h0000_0078;
  localparam logic [31:0] AUX_KEEP  = 32'h0000_0033;
  localparam logic [31:0] TTB_KEEP  = 32'hFFFF_C000;
  localparam logic [31:0] FSR_KEEP  = 32'h0000_06FF;
  localparam logic [31:0] PID_KEEP  = 32'hFE00_0000;
  localparam logic [31:0] CPA_KEEP  = 32'h0000_3FFF;
  localparam int          NBP       = 5;
  localparam int          END_BIT   = 7;

  logic        legal;
  logic        op2z;
  logic        we;
  logic [2:0]  bp_idx;
  logic        bp_hit;
  logic [31:0] ctrl_q, aux_q, ttb_q, dac_q, fsr_q, far_q, pid_q, cpa_q;
  logic        dcl_q;
  logic [31:0] bp_q [NBP];
  logic        pulse_q;
  logic [31:0] rd_mux;

  assign op2z = (req_op2 == 3'd0);

  always_comb begin
    bp_hit = 1'b1;
    bp_idx = 3'd0;
    case (req_crm)
      4'd0:    bp_idx = 3'd0;
      4'd3:    bp_idx = 3'd1;
      4'd4:    bp_idx = 3'd2;
      4'd8:    bp_idx = 3'd3;
      4'd9:    bp_idx = 3'd4;
      default: bp_hit = 1'b0;
    endcase
  end

  always_comb begin
    legal = 1'b0;
    if (req_priv && req_op1 == 3'd0) begin
      case (req_crn)
        4'd0, 4'd1: legal = (req_crm == 4'd0);
        4'd2, 4'd3, 4'd5, 4'd6, 4'd13: legal = (req_crm == 4'd0) && op2z;
        4'd7: begin
          case (req_op2)
            3'd0: legal = (req_crm >= 4'd5) && (req_crm <= 4'd7);
            3'd1: legal = (req_crm == 4'd5) || (req_crm == 4'd6) || (req_crm == 4'd10);
            3'd4: legal = (req_crm == 4'd10);
            3'd5: legal = (req_crm == 4'd2);
            3'd6: legal = (req_crm == 4'd5);
            default: legal = 1'b0;
          endcase
        end
        4'd8: legal = (req_crm >= 4'd5) && (req_crm <= 4'd7) &&
                      (op2z || (req_op2 == 3'd1 && req_crm != 4'd7));
        4'd9:  legal = (req_crm == 4'd1 || req_crm == 4'd2) && (req_op2 <= 3'd1);
        4'd10: legal = (req_crm == 4'd4 || req_crm == 4'd8) && (req_op2 <= 3'd1);
        4'd14: legal = bp_hit && op2z;
        4'd15: legal = (req_crm == 4'd1) && op2z;
        default: legal = 1'b0;
      endcase
    end
  end

  assign acc_ok = req_valid && legal;
  assign we     = acc_ok && req_write;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RESET;
      aux_q   <= '0;
      ttb_q   <= '0;
      dac_q   <= '0;
      fsr_q   <= '0;
      far_q   <= '0;
      pid_q   <= '0;
      cpa_q   <= '0;
      dcl_q   <= 1'b0;
      pulse_q <= 1'b0;
      for (int i = 0; i < NBP; i++) bp_q[i] <= '0;
    end else begin
      pulse_q <= 1'b0;
      if (we) begin
        case (req_crn)
          4'd1: begin
            if (op2z) begin
              ctrl_q  <= (req_wdata & CTRL_KEEP) | CTRL_ONES;
              pulse_q <= (req_wdata[END_BIT] != ctrl_q[END_BIT]);
            end else begin
              aux_q <= req_wdata & AUX_KEEP;
            end
          end
          4'd2:  ttb_q <= req_wdata & TTB_KEEP;
          4'd3:  dac_q <= req_wdata;
          4'd5:  fsr_q <= req_wdata & FSR_KEEP;
          4'd6:  far_q <= req_wdata;
          4'd9:  dcl_q <= req_wdata[0];
          4'd13: pid_q <= req_wdata & PID_KEEP;
          4'd14: bp_q[bp_idx] <= req_wdata;
          4'd15: cpa_q <= req_wdata & CPA_KEEP;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (req_crn)
      4'd0:    rd_mux = op2z ? ID_VALUE : CACHE_TYPE;
      4'd1:    rd_mux = op2z ? ctrl_q : aux_q;
      4'd2:    rd_mux = ttb_q;
      4'd3:    rd_mux = dac_q;
      4'd5:    rd_mux = fsr_q;
      4'd6:    rd_mux = far_q;
      4'd9:    rd_mux = {31'd0, dcl_q};
      4'd13:   rd_mux = pid_q;
      4'd14:   rd_mux = bp_q[bp_idx];
      4'd15:   rd_mux = cpa_q;
      default: rd_mux = '0;
    endcase
  end

  assign rd_data      = (acc_ok && !req_write) ? rd_mux : 32'd0;
  assign endian_pulse = pulse_q;
endmodule

module sysctl_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic        req_priv,
  input logic [2:0]  req_op1,
  input logic        acc_ok,
  input logic [31:0] rd_data,
  input logic        endian_pulse,
  input logic [31:0] ctrl_q
);
  a_r1_user_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (!req_priv || req_op1 != 3'd0)) |-> !acc_ok);

  a_r3_ctrl_forced: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q & 32'hFFFF_C478) == 32'h0000_0078);

  a_r9_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
    endian_pulse |-> (ctrl_q[7] != $past(ctrl_q[7])));

  a_r9_change_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7] != $past(ctrl_q[7])) |-> endian_pulse);

  a_r10_reject_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !acc_ok) |-> (rd_data == 32'd0));

  a_r10_reject_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !acc_ok) |=> $stable(ctrl_q));
endmodule

bind sysctl_regs sysctl_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_priv(req_priv), .req_op1(req_op1), .acc_ok(acc_ok), .rd_data(rd_data),
  .endian_pulse(endian_pulse), .ctrl_q(ctrl_q)
);

// File: tb/sysctl_regs_bench.sv
module sysctl_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
  logic [3:0]  req_crn = '0, req_crm = '0;
  logic [2:0]  req_op1 = '0, req_op2 = '0;
  logic [31:0] req_wdata = '0;
  logic        acc_ok, endian_pulse;
  logic [31:0] rd_data;

  int checks = 0, fails = 0;

  logic [31:0] m_ctrl, m_aux, m_ttb, m_dac, m_fsr, m_far, m_pid, m_cpa;
  logic        m_dcl;
  logic [31:0] m_bp [5];

  always #5 clk = ~clk;

  sysctl_regs u_sysctl_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_priv(req_priv), .req_crn(req_crn), .req_crm(req_crm), .req_op1(req_op1),
    .req_op2(req_op2), .req_wdata(req_wdata), .acc_ok(acc_ok), .rd_data(rd_data),
    .endian_pulse(endian_pulse)
  );

  function automatic bit in_set(logic [3:0] v, logic [3:0] a, logic [3:0] b, logic [3:0] c);
    return (v == a) || (v == b) || (v == c);
  endfunction

  function automatic int bp_slot(logic [3:0] crm);
    case (crm)
      4'd0: return 0;
      4'd3: return 1;
      4'd4: return 2;
      4'd8: return 3;
      4'd9: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic bit exp_legal(bit priv, logic [3:0] n, logic [3:0] m, logic [2:0] o1, logic [2:0] o2);
    if (!priv || o1 != 0) return 0;
    case (n)
      0, 1: return m == 0;
      2, 3, 5, 6, 13: return m == 0 && o2 == 0;
      7: begin
        if (o2 == 0) return in_set(m, 5, 6, 7);
        if (o2 == 1) return in_set(m, 5, 6, 10);
        if (o2 == 4) return m == 10;
        if (o2 == 5) return m == 2;
        if (o2 == 6) return m == 5;
        return 0;
      end
      8: return (o2 == 0 && in_set(m, 5, 6, 7)) || (o2 == 1 && in_set(m, 5, 6, 6));
      9: return (m == 1 || m == 2) && o2 < 2;
      10: return (m == 4 || m == 8) && o2 < 2;
      14: return o2 == 0 && bp_slot(m) >= 0;
      15: return m == 1 && o2 == 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] exp_read(logic [3:0] n, logic [3:0] m, logic [2:0] o2);
    case (n)
      0: return (o2 == 0) ? 32'h6905_2000 : 32'h0B1A_A1AA;
      1: return (o2 == 0) ? m_ctrl : m_aux;
      2: return m_ttb;
      3: return m_dac;
      5: return m_fsr;
      6: return m_far;
      9: return {31'd0, m_dcl};
      13: return m_pid;
      14: return (bp_slot(m) >= 0) ? m_bp[bp_slot(m)] : 32'd0;
      15: return m_cpa;
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic access(string tag, bit wr, bit priv, logic [3:0] n, logic [3:0] m,
                        logic [2:0] o1, logic [2:0] o2, logic [31:0] d);
    bit lg;
    bit flip;
    logic [31:0] er;
    lg = exp_legal(priv, n, m, o1, o2);
    er = (lg && !wr) ? exp_read(n, m, o2) : 32'd0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_priv = priv; req_crn = n; req_crm = m;
    req_op1 = o1; req_op2 = o2; req_wdata = d;
    #1;
    check({tag, " acc_ok"}, {31'd0, acc_ok}, {31'd0, lg});
    check({tag, " rd_data"}, rd_data, er);
    flip = 0;
    if (lg && wr) begin
      case (n)
        1: if (o2 == 0) begin
             flip = (d[7] != m_ctrl[7]);
             m_ctrl = (d & 32'h3B87) | 32'h78;
           end else m_aux = d & 32'h33;
        2: m_ttb = d & 32'hFFFF_C000;
        3: m_dac = d;
        5: m_fsr = d & 32'h6FF;
        6: m_far = d;
        9: m_dcl = d[0];
        13: m_pid = d & 32'hFE00_0000;
        14: m_bp[bp_slot(m)] = d;
        15: m_cpa = d & 32'h3FFF;
        default: ;
      endcase
    end
    @(posedge clk);
    #2;
    check({tag, " R9 endian_pulse"}, {31'd0, endian_pulse}, {31'd0, flip});
    req_valid = 0;
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    m_ctrl = 32'h78; m_aux = 0; m_ttb = 0; m_dac = 0; m_fsr = 0; m_far = 0;
    m_pid = 0; m_cpa = 0; m_dcl = 0;
    for (int i = 0; i < 5; i++) m_bp[i] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1 check("R9 reset pulse", {31'd0, endian_pulse}, 32'd0);

    access("R2 id", 0, 1, 0, 0, 0, 0, 0);
    access("R2 cachetype", 0, 1, 0, 0, 0, 3, 0);
    access("R2 ctrl reset", 0, 1, 1, 0, 0, 0, 0);
    access("R2 id write", 1, 1, 0, 0, 0, 0, 32'hDEAD_BEEF);
    access("R2 id after", 0, 1, 0, 0, 0, 0, 0);
    access("R1 user", 1, 0, 3, 0, 0, 0, 32'h1234_5678);
    access("R1 op1", 1, 1, 3, 0, 2, 0, 32'h1234_5678);
    access("R10 dac held", 0, 1, 3, 0, 0, 0, 0);
    access("R3 ctrl ones", 1, 1, 1, 0, 0, 0, 32'hFFFF_FFFF);
    access("R3 ctrl read", 0, 1, 1, 0, 0, 0, 0);
    access("R9 same bit", 1, 1, 1, 0, 0, 0, 32'h0000_0080);
    access("R9 clear bit", 1, 1, 1, 0, 0, 0, 32'h0000_0000);
    access("R3 ctrl zero", 0, 1, 1, 0, 0, 0, 0);
    access("R4 aux", 1, 1, 1, 0, 0, 2, 32'hFFFF_FFFF);
    access("R4 aux read", 0, 1, 1, 0, 0, 2, 0);
    access("R5 fsr", 1, 1, 5, 0, 0, 0, 32'hFFFF_FFFF);
    access("R5 fsr read", 0, 1, 5, 0, 0, 0, 0);
    access("R6 bp ctl", 1, 1, 14, 4, 0, 0, 32'hA5A5_5A5A);
    access("R6 bp ctl read", 0, 1, 14, 4, 0, 0, 0);
    access("R6 bp bad", 1, 1, 14, 5, 0, 0, 32'h1);
    access("R7 cpa bad", 1, 1, 15, 0, 0, 0, 32'hFFFF);
    access("R7 cpa", 1, 1, 15, 1, 0, 0, 32'hFFFF_FFFF);
    access("R7 cpa read", 0, 1, 15, 1, 0, 0, 0);
    access("R8 reg4", 1, 1, 4, 0, 0, 0, 32'h1);
    access("R8 cache op", 1, 1, 7, 10, 0, 4, 32'hFFFF_FFFF);
    access("R8 cache read", 0, 1, 7, 10, 0, 4, 0);
    access("R8 dcl", 1, 1, 9, 2, 0, 1, 32'hFFFF_FFFF);
    access("R8 dcl read", 0, 1, 9, 1, 0, 0, 0);
    access("R8 tlb reject", 0, 1, 8, 7, 0, 1, 0);

    for (int k = 0; k < 1500; k++) begin
      bit wr, pv;
      logic [3:0] n, m;
      logic [2:0] o1, o2;
      wr = $urandom_range(0, 1);
      pv = ($urandom_range(0, 7) != 0);
      n = 4'($urandom_range(0, 15));
      m = ($urandom_range(0, 3) == 0) ? 4'($urandom_range(0, 15)) : 4'($urandom_range(0, 10));
      if (n == 15 && $urandom_range(0, 1) == 1) m = 1;
      if ((n <= 6 || n == 13) && $urandom_range(0, 1) == 1) m = 0;
      o1 = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : 3'd0;
      o2 = ($urandom_range(0, 2) == 0) ? 3'($urandom_range(0, 7)) : 3'($urandom_range(0, 1));
      access("R10 random", wr, pv, n, m, o1, o2, $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule